// File: doc/BRIEF.md
# Search Coprocessor SRAM Access Sequencer

This block runs on the device side of a search coprocessor. It carries out host-requested reads and writes to an external SRAM that holds associative data. The host sends an instruction over two back-to-back cycles on a small command bus, marked by a command-valid strobe. It also supplies a select code, a target device identifier and a row address on the wide data bus. When the instruction is for this device and targets the SRAM, the sequencer builds a 22-bit SRAM address. It places that address on the SRAM address pins in a single cycle together with active-low chip-enable and address-latch strobes. The delay before that cycle is set by a search-latency setting.

A read is blocking. The device takes over the data bus and runs a three-phase acknowledge: driven low, one high pulse, driven low, then released. The high pulse trails the address strobe by a hit-latency setting. A write is pipelined: it never touches the acknowledge line, and the next instruction may start in the cycle right after its second cycle. The pads are not modelled as tri-state nets. Separate output-enable pins tell the pad ring when the device drives the data bus, the SRAM address bus and the acknowledge line.

The command interface has a valid strobe but no ready signal, because the host cannot be held off. During a read the host must keep the command strobe low until the acknowledge completes. Any command-valid seen in that window is dropped and latches a sticky protocol-error flag.

Top module: `ssq_sram_seq`

## Requirements
- R1: While reset is held and in the first cycle after it is released, ack_oe, ack_o, dq_oe and sadr_oe are 0, sce_n and sale_n are 1, and proto_err is 0.
- R2: An instruction is accepted only under all of the following conditions. cmd_vld is high in two consecutive cycles (called A and B). dq_i[20:19] equals 2'b10 in both A and B. dq_i[25:21] equals dev_id in A. cmd_op is the same in A and B and is either 2'b01 (read) or 2'b10 (write). Any other pattern produces no address strobe and no acknowledge activity.
- R3: The SRAM address of an accepted instruction is {cmd_ext, 5'b00000, dq_i[14:0]}, where cmd_ext and dq_i are sampled in cycle A. sadr_o shows that value in the strobe cycle and shows zero in every other cycle.
- R4: For a read, sce_n and sale_n are 0 and sadr_oe is 1 in exactly one cycle, A+5+S. S is the cfg_srch_lat value sampled in cycle B.
- R5: For a read, ack_oe is 1 from cycle A+4+S through cycle A+6+S+H, and ack_o is 1 only in cycle A+5+S+H. H is the cfg_hit_lat value sampled in cycle B.
- R6: For a read, dq_oe is 1 in cycles A+4+S and A+5+S only.
- R7: For a write, sce_n and sale_n are 0 and sadr_oe is 1 in exactly one cycle, A+6+S (five plus S cycles after cycle B). ack_oe and ack_o stay 0.
- R8: After a write, a new instruction may begin in cycle A+2. Back-to-back writes, and a read that follows a write at once, each produce their own strobe at their own scheduled cycle.
- R9: After an accepted read, any cycle from A+2 through A+6+S+H that has cmd_vld high is dropped (no strobe, no acknowledge) and sets proto_err from the next cycle on. A new instruction is accepted again from cycle A+7+S+H.
- R10: Once set, proto_err stays 1 until reset. It does not stop later valid instructions from being accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_vld | input | 1 | Command-valid strobe, high in both instruction cycles |
| cmd_op | input | 2 | Opcode: 2'b01 read, 2'b10 write |
| cmd_ext | input | 2 | Upper SRAM address bits, sampled in cycle A |
| dq_i | input | 68 | Data bus from the host: [25:21] device ID, [20:19] select, [14:0] row address |
| dev_id | input | 5 | This device's identifier |
| cfg_srch_lat | input | 2 | Search-latency setting S (extra cycles before the strobe) |
| cfg_hit_lat | input | 3 | Hit-latency setting H (extra cycles before the acknowledge pulse) |
| dq_oe | output | 1 | Device drives the data bus |
| sadr_o | output | 22 | SRAM address |
| sadr_oe | output | 1 | Device drives the SRAM address bus |
| sce_n | output | 1 | SRAM chip enable, active low |
| sale_n | output | 1 | SRAM address latch enable, active low |
| ack_o | output | 1 | Acknowledge level |
| ack_oe | output | 1 | Device drives the acknowledge line |
| proto_err | output | 1 | Sticky flag: command-valid seen while a read was blocking |

## Verification
Some properties are checked on every cycle. These are the single-cycle width of the acknowledge pulse, the low level of the acknowledge before release, the fact that the data-bus window lies inside the acknowledge window, and the stickiness of the error flag. They also include the alignment between the read tracker's phase count and the strobe from the address delay line, and the absence of slot collisions in that delay line. Other behaviour can only be shown by the bench's scenarios. This covers the exact cycles of each strobe and acknowledge phase under several latency settings, the address bits, the rejection of each malformed instruction, write pipelining, the earliest restart after a read, and the dropping of commands during a read.

// File: rtl/ssq_pkg.sv
package ssq_pkg;
  localparam int DQ_W    = 68;
  localparam int SADR_W  = 22;
  localparam int ROW_W   = 15;
  localparam int ID_W    = 5;
  localparam int SEL_LSB = 19;
  localparam int ID_LSB  = 21;
  localparam logic [1:0] SEL_SRAM = 2'b10;

  typedef enum logic [1:0] {
    OP_NOP = 2'b00,
    OP_RD  = 2'b01,
    OP_WR  = 2'b10,
    OP_RSV = 2'b11
  } op_e;

  typedef struct packed {
    logic              vld;
    logic [SADR_W-1:0] addr;
  } slot_t;
endpackage

// File: rtl/ssq_decode.sv
module ssq_decode
  import ssq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_vld,
  input  logic [1:0]        cmd_op,
  input  logic [1:0]        cmd_ext,
  input  logic [DQ_W-1:0]   dq_i,
  input  logic [ID_W-1:0]   dev_id,
  input  logic              rd_busy,
  output logic              rd_go,
  output logic              wr_go,
  output logic [SADR_W-1:0] go_addr,
  output logic              proto_err
);
  localparam int PAD = SADR_W - 2 - ROW_W;

  logic              half_q;
  op_e               op_q;
  logic [SADR_W-1:0] addr_q;
  logic              sel_ok, id_ok, op_ok, first_ok, second_ok;

  always_comb begin
    sel_ok    = (dq_i[SEL_LSB +: 2] == SEL_SRAM);
    id_ok     = (dq_i[ID_LSB +: ID_W] == dev_id);
    op_ok     = (op_e'(cmd_op) == OP_RD) || (op_e'(cmd_op) == OP_WR);
    first_ok  = !half_q && !rd_busy && cmd_vld && sel_ok && id_ok && op_ok;
    second_ok = half_q && cmd_vld && sel_ok && (op_e'(cmd_op) == op_q);
    rd_go     = second_ok && (op_q == OP_RD);
    wr_go     = second_ok && (op_q == OP_WR);
    go_addr   = addr_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      half_q    <= 1'b0;
      op_q      <= OP_NOP;
      addr_q    <= '0;
      proto_err <= 1'b0;
    end else begin
      half_q <= first_ok;
      if (first_ok) begin
        op_q   <= op_e'(cmd_op);
        addr_q <= {cmd_ext, {PAD{1'b0}}, dq_i[ROW_W-1:0]};
      end
      if (!half_q && rd_busy && cmd_vld) proto_err <= 1'b1;
    end
  end

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);

  // R2
  go_needs_prior_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go || wr_go) |-> $past(cmd_vld));
endmodule

// File: rtl/ssq_addr_pipe.sv
module ssq_addr_pipe
  import ssq_pkg::*;
#(
  parameter int SW = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_go,
  input  logic              wr_go,
  input  logic [SADR_W-1:0] go_addr,
  input  logic [SW-1:0]     srch_lat,
  output logic [SADR_W-1:0] sadr_o,
  output logic              sadr_oe,
  output logic              sce_n,
  output logic              sale_n
);
  localparam int NSRCH = 1 << SW;
  localparam int L     = NSRCH + 4;
  localparam int LW    = $clog2(L);

  slot_t      pipe [L];
  logic [LW-1:0] rd_j, wr_j;

  always_comb begin
    rd_j = LW'(L - 4) - LW'(srch_lat);
    wr_j = LW'(L - 5) - LW'(srch_lat);
  end

  for (genvar i = 0; i < L; i++) begin : g_slot
    logic hit;
    assign hit = (rd_go && rd_j == LW'(i)) || (wr_go && wr_j == LW'(i));
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n)   pipe[i] <= '0;
        else if (hit) pipe[i] <= '{vld: 1'b1, addr: go_addr};
        else          pipe[i] <= '0;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (!rst_n)   pipe[i] <= '0;
        else if (hit) pipe[i] <= '{vld: 1'b1, addr: go_addr};
        else          pipe[i] <= pipe[i-1];
      end
    end
  end

  always_comb begin
    sadr_oe = pipe[L-1].vld;
    sce_n   = !pipe[L-1].vld;
    sale_n  = !pipe[L-1].vld;
    sadr_o  = pipe[L-1].vld ? pipe[L-1].addr : '0;
  end

  // R8
  no_slot_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |-> !pipe[rd_j - LW'(1)].vld);
endmodule

// File: rtl/ssq_rd_track.sv
module ssq_rd_track #(
  parameter int SW = 2,
  parameter int HW = 3,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_go,
  input  logic [SW-1:0] srch_lat,
  input  logic [HW-1:0] hit_lat,
  output logic          rd_busy,
  output logic [CW-1:0] rd_phase,
  output logic [SW-1:0] rd_slat,
  output logic          ack_o,
  output logic          ack_oe,
  output logic          dq_oe
);
  logic [SW-1:0] s_q;
  logic [HW-1:0] h_q;
  logic [CW-1:0] cnt, last_c, drv_c, pulse_c;

  always_comb begin
    drv_c   = CW'(4) + CW'(s_q);
    pulse_c = CW'(5) + CW'(s_q) + CW'(h_q);
    last_c  = CW'(6) + CW'(s_q) + CW'(h_q);
    ack_oe  = rd_busy && (cnt >= drv_c);
    ack_o   = rd_busy && (cnt == pulse_c);
    dq_oe   = rd_busy && ((cnt == drv_c) || (cnt == drv_c + CW'(1)));
    rd_phase = cnt;
    rd_slat  = s_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_busy <= 1'b0;
      cnt     <= '0;
      s_q     <= '0;
      h_q     <= '0;
    end else if (rd_go) begin
      rd_busy <= 1'b1;
      cnt     <= CW'(2);
      s_q     <= srch_lat;
      h_q     <= hit_lat;
    end else if (rd_busy) begin
      if (cnt == last_c) begin
        rd_busy <= 1'b0;
        cnt     <= '0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  // R5
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |=> !ack_o);

  // R5
  ack_low_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_oe) |-> !$past(ack_o));

  // R6
  dq_in_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> ack_oe);
endmodule

// File: rtl/ssq_sram_seq.sv
module ssq_sram_seq
  import ssq_pkg::*;
#(
  parameter int SW = 2,
  parameter int HW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_vld,
  input  logic [1:0]        cmd_op,
  input  logic [1:0]        cmd_ext,
  input  logic [DQ_W-1:0]   dq_i,
  input  logic [ID_W-1:0]   dev_id,
  input  logic [SW-1:0]     cfg_srch_lat,
  input  logic [HW-1:0]     cfg_hit_lat,
  output logic              dq_oe,
  output logic [SADR_W-1:0] sadr_o,
  output logic              sadr_oe,
  output logic              sce_n,
  output logic              sale_n,
  output logic              ack_o,
  output logic              ack_oe,
  output logic              proto_err
);
  localparam int MAXC = 6 + ((1 << SW) - 1) + ((1 << HW) - 1);
  localparam int CW   = $clog2(MAXC + 1);

  logic              rd_go, wr_go, rd_busy;
  logic [SADR_W-1:0] go_addr;
  logic [CW-1:0]     rd_phase;
  logic [SW-1:0]     rd_slat;

  ssq_decode u_dec (
    .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_op(cmd_op),
    .cmd_ext(cmd_ext), .dq_i(dq_i), .dev_id(dev_id), .rd_busy(rd_busy),
    .rd_go(rd_go), .wr_go(wr_go), .go_addr(go_addr), .proto_err(proto_err)
  );

  ssq_addr_pipe #(.SW(SW)) u_pipe (
    .clk(clk), .rst_n(rst_n), .rd_go(rd_go), .wr_go(wr_go),
    .go_addr(go_addr), .srch_lat(cfg_srch_lat), .sadr_o(sadr_o),
    .sadr_oe(sadr_oe), .sce_n(sce_n), .sale_n(sale_n)
  );

  ssq_rd_track #(.SW(SW), .HW(HW), .CW(CW)) u_trk (
    .clk(clk), .rst_n(rst_n), .rd_go(rd_go), .srch_lat(cfg_srch_lat),
    .hit_lat(cfg_hit_lat), .rd_busy(rd_busy), .rd_phase(rd_phase),
    .rd_slat(rd_slat), .ack_o(ack_o), .ack_oe(ack_oe), .dq_oe(dq_oe)
  );

  // R9
  rd_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |=> rd_busy);

  // R4
  rd_strobe_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_busy && rd_phase == CW'(5) + CW'(rd_slat)) |-> !sce_n);
endmodule

// File: tb/ssq_sram_seq_tb_top.sv
module ssq_sram_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_vld = 1'b0;
  logic [1:0]  cmd_op = '0;
  logic [1:0]  cmd_ext = '0;
  logic [67:0] dq_i = '0;
  logic [4:0]  dev_id = 5'h0B;
  logic [1:0]  cfg_srch_lat = '0;
  logic [2:0]  cfg_hit_lat = '0;
  logic        dq_oe, sadr_oe, sce_n, sale_n, ack_o, ack_oe, proto_err;
  logic [21:0] sadr_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  ssq_sram_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_op(cmd_op),
    .cmd_ext(cmd_ext), .dq_i(dq_i), .dev_id(dev_id),
    .cfg_srch_lat(cfg_srch_lat), .cfg_hit_lat(cfg_hit_lat), .dq_oe(dq_oe),
    .sadr_o(sadr_o), .sadr_oe(sadr_oe), .sce_n(sce_n), .sale_n(sale_n),
    .ack_o(ack_o), .ack_oe(ack_oe), .proto_err(proto_err)
  );

  typedef struct { int t; logic [21:0] a; string req; } strobe_t;

  int      cyc = 0;
  int      n_vec = 0, n_bad = 0;
  bit      mon_on = 0;
  int      err_from = 32'h7fffffff;
  int      rd_free_at = 0;
  bit      exp_ack_oe [int];
  bit      exp_ack_hi [int];
  bit      exp_dq_oe  [int];
  strobe_t sq [$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cyc + 1, act, exp);
    end
  endtask

  // Monitor: compares outputs against the expectations the driver pushed.
  always @(negedge clk) begin
    if (mon_on) begin
      int  t;
      bit  exp_s;
      logic [2:0] st_exp;
      string tag;
      t = cyc + 1;
      chk(ack_oe == exp_ack_oe.exists(t), "R5/R7 ack_oe", 32'(ack_oe), 32'(exp_ack_oe.exists(t)));
      chk(ack_o == exp_ack_hi.exists(t), "R5 ack_o", 32'(ack_o), 32'(exp_ack_hi.exists(t)));
      chk(dq_oe == exp_dq_oe.exists(t), "R6 dq_oe", 32'(dq_oe), 32'(exp_dq_oe.exists(t)));
      chk(proto_err == (t >= err_from), "R9/R10 proto_err", 32'(proto_err), 32'(t >= err_from));
      exp_s  = (sq.size() > 0) && (sq[0].t == t);
      st_exp = exp_s ? 3'b001 : 3'b110;
      tag    = exp_s ? sq[0].req : "R2 unexpected strobe";
      chk({sce_n, sale_n, sadr_oe} == st_exp, tag, 32'({sce_n, sale_n, sadr_oe}), 32'(st_exp));
      if (exp_s) begin
        chk(sadr_o == sq[0].a, "R3 address", 32'(sadr_o), 32'(sq[0].a));
        void'(sq.pop_front());
      end else begin
        chk(sadr_o == '0, "R3 idle address", 32'(sadr_o), 0);
        if (sq.size() > 0 && sq[0].t < t) void'(sq.pop_front());
      end
    end
  end

  function automatic logic [67:0] dq_word(input logic [4:0] id, input logic [1:0] sel, input logic [14:0] row);
    logic [67:0] d;
    d = '0;
    d[25:21] = id;
    d[20:19] = sel;
    d[14:0]  = row;
    return d;
  endfunction

  task automatic go_idle();
    @(negedge clk);
    cmd_vld = 0; cmd_op = '0; cmd_ext = '0; dq_i = '0;
  endtask

  task automatic idle_n(input int n);
    for (int i = 0; i < n; i++) go_idle();
  endtask

  task automatic wait_to(input int t);
    while (cyc + 2 < t) @(negedge clk);
  endtask

  // Driver: drives cycles A and B and pushes the expected results.
  task automatic issue(input logic [1:0] op_a, input logic [1:0] op_b,
                       input logic [4:0] id, input logic [1:0] sel_a,
                       input logic [1:0] sel_b, input bit vld_b,
                       input logic [1:0] ext, input logic [14:0] row,
                       input bit ok, input string req);
    int t0, s, h;
    logic [21:0] a;
    @(negedge clk);
    t0 = cyc + 1;
    cmd_vld = 1; cmd_op = op_a; cmd_ext = ext; dq_i = dq_word(id, sel_a, row);
    s = int'(cfg_srch_lat);
    h = int'(cfg_hit_lat);
    a = {ext, 5'b00000, row};
    if (ok && op_a == 2'b01) begin
      sq.push_back('{t0 + 5 + s, a, {req, " R4 read strobe"}});
      for (int c = t0 + 4 + s; c <= t0 + 6 + s + h; c++) exp_ack_oe[c] = 1;
      exp_ack_hi[t0 + 5 + s + h] = 1;
      exp_dq_oe[t0 + 4 + s] = 1;
      exp_dq_oe[t0 + 5 + s] = 1;
      rd_free_at = t0 + 7 + s + h;
    end else if (ok && op_a == 2'b10) begin
      sq.push_back('{t0 + 6 + s, a, {req, " R7 write strobe"}});
    end
    @(negedge clk);
    cmd_vld = vld_b; cmd_op = op_b; cmd_ext = 2'b11 ^ ext;
    dq_i = dq_word(~id, sel_b, ~row);
  endtask

  task automatic do_reset();
    @(negedge clk);
    mon_on = 0;
    rst_n = 0;
    cmd_vld = 0;
    idle_n(3);
    rst_n = 1;
    err_from = 32'h7fffffff;
    // R1: idle outputs right after reset release
    chk({ack_oe, ack_o, dq_oe, sadr_oe, sce_n, sale_n, proto_err} == 7'b0000110,
        "R1 reset state", 32'({ack_oe, ack_o, dq_oe, sadr_oe, sce_n, sale_n, proto_err}), 32'(7'b0000110));
    mon_on = 1;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", WD_CYCLES);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    idle_n(2);
    // R1
    chk({sce_n, sale_n, ack_oe, sadr_oe} == 4'b1100, "R1 during reset",
        32'({sce_n, sale_n, ack_oe, sadr_oe}), 32'(4'b1100));
    do_reset();

    // R4 R5 R6: minimum latency read
    issue(2'b01, 2'b01, 5'h0B, 2'b10, 2'b10, 1, 2'b10, 15'h1234, 1, "R3");
    idle_n(14);
    // R7: minimum latency write
    issue(2'b10, 2'b10, 5'h0B, 2'b10, 2'b10, 1, 2'b01, 15'h7FFF, 1, "R3");
    idle_n(14);

    // R4 R5: longer latencies
    cfg_srch_lat = 2'd2; cfg_hit_lat = 3'd3;
    issue(2'b01, 2'b01, 5'h0B, 2'b10, 2'b10, 1, 2'b11, 15'h0001, 1, "R5 s2h3");
    idle_n(20);
    cfg_srch_lat = 2'd3; cfg_hit_lat = 3'd7;
    issue(2'b01, 2'b01, 5'h0B, 2'b10, 2'b10, 1, 2'b00, 15'h4AAA, 1, "R5 s3h7");
    idle_n(24);

    // R8: back-to-back writes then a read right after
    cfg_srch_lat = 2'd1; cfg_hit_lat = 3'd2;
    issue(2'b10, 2'b10, 5'h0B, 2'b10, 2'b10, 1, 2'b01, 15'h0100, 1, "R8 w0");
    issue(2'b10, 2'b10, 5'h0B, 2'b10, 2'b10, 1, 2'b10, 15'h0200, 1, "R8 w1");
    issue(2'b10, 2'b10, 5'h0B, 2'b10, 2'b10, 1, 2'b11, 15'h0300, 1, "R8 w2");
    issue(2'b01, 2'b01, 5'h0B, 2'b10, 2'b10, 1, 2'b00, 15'h0400, 1, "R8 rd");
    idle_n(20);

    // R2: malformed instructions are ignored
    issue(2'b01, 2'b01, 5'h0C, 2'b10, 2'b10, 1, 2'b01, 15'h0011, 0, "R2 id");
    go_idle();
    issue(2'b01, 2'b01, 5'h0B, 2'b01, 2'b10, 1, 2'b01, 15'h0022, 0, "R2 selA");
    go_idle();
    issue(2'b10, 2'b10, 5'h0B, 2'b10, 2'b11, 1, 2'b01, 15'h0033, 0, "R2 selB");
    go_idle();
    issue(2'b01, 2'b01, 5'h0B, 2'b10, 2'b10, 0, 2'b01, 15'h0044, 0, "R2 vldB");
    go_idle();
    issue(2'b11, 2'b11, 5'h0B, 2'b10, 2'b10, 1, 2'b01, 15'h0055, 0, "R2 op11");
    go_idle();
    issue(2'b00, 2'b00, 5'h0B, 2'b10, 2'b10, 1, 2'b01, 15'h0066, 0, "R2 op00");
    go_idle();
    issue(2'b01, 2'b10, 5'h0B, 2'b10, 2'b10, 1, 2'b01, 15'h0077, 0, "R2 opchg");
    idle_n(20);

    // R9: earliest restart after a read is accepted
    issue(2'b01, 2'b01, 5'h0B, 2'b10, 2'b10, 1, 2'b10, 15'h0ABC, 1, "R9 first");
    go_idle();
    wait_to(rd_free_at);
    issue(2'b01, 2'b01, 5'h0B, 2'b10, 2'b10, 1, 2'b01, 15'h0DEF, 1, "R9 restart");
    idle_n(20);

    // R9 R10: command during a blocking read is dropped and flagged
    cfg_srch_lat = 2'd3; cfg_hit_lat = 3'd4;
    issue(2'b01, 2'b01, 5'h0B, 2'b10, 2'b10, 1, 2'b11, 15'h0F0F, 1, "R9 blk");
    go_idle();
    err_from = cyc + 3;
    issue(2'b10, 2'b10, 5'h0B, 2'b10, 2'b10, 1, 2'b01, 15'h0BAD, 0, "R9 dropped");
    go_idle();
    wait_to(rd_free_at);
    issue(2'b10, 2'b10, 5'h0B, 2'b10, 2'b10, 1, 2'b10, 15'h0600, 1, "R10 after err");
    idle_n(20);
    // R10: flag still set long after
    chk(proto_err == 1'b1, "R10 sticky", 32'(proto_err), 1);

    do_reset();
    idle_n(4);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule